// File: doc/BRIEF.md
# Ping-Pong Page Cache for Continuous Page Reads

This block is the device-side read path of a NAND-style memory. It has a page cache split into two halves, each one page plus its spare bytes wide, and an array model with a fixed load latency. In the normal mode a host command loads one page into the cache. The block reports busy while the load runs. The host then pulls bytes one at a time, starting at a column it chooses and running through the spare bytes.

When the streaming bit of the configuration register is set, a command starts a continuous stream instead. The block streams whole pages with main bytes only. While the host drains one half, the block fetches the next sequential page into the other half. At the end of each page the two halves trade roles on their own. If the host reads faster than the array can load, the data-valid output holds low until the pending half is full. The stream stops issuing loads after the last page of the erase block it started in.

The stream can end in two ways. Releasing chip-select puts the block into a recovery wait, during which it reports busy. Writing the streaming bit to zero ends the stream at once.

Top module: `ppc_cont_read`

## Requirements
- R1: After reset `busy` and `rd_valid` are 0.
- R2: With the streaming bit clear, an accepted command for page p and column c makes `busy` 1 from the next cycle until the page is loaded. After that, each request yields one byte for columns c up to PAGE_BYTES+SPARE_BYTES-1, and no further bytes follow. The byte at page p, column k has the value (29*p + 7*k + 60) mod 256.
- R3: With the streaming bit set, the column of the command is ignored. Output starts at byte 0 of page p, and only the PAGE_BYTES main bytes of each page are output.
- R4: In streaming mode, pages follow as p, p+1, p+2 and so on with no further command. Each page after the first is fetched into the idle half while the other half is being output.
- R5: When the next half is not yet loaded, `rd_valid` stays 0 under a held request and the byte order is kept. No byte is output without a request.
- R6: A stream ends after the last page of the erase block of p, where the erase block is p / PAGES_PER_BLK. After that, requests yield nothing.
- R7: If `cs_n` goes high during a stream, `busy` is 1 for exactly RECOV_CYC cycles, starting in the next cycle. After that a new command is accepted.
- R8: A configuration write with `cfg_cont`=0 during a stream ends it with no recovery wait. `busy` is 0 in the next cycle and no further bytes are output.
- R9: If `cs_n` goes high during a normal read, the block goes idle without a busy period and outputs no more bytes.
- R10: A command presented while `busy` is 1 is ignored.
- R11: `rd_valid` is 1 only in the cycle after `rd_req` was sampled 1 with `cs_n` low.
- R12: A `cfg_we` pulse stores `cfg_cont` as the streaming bit. The bit in force when a command is accepted selects that command's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip-select, active low |
| cmd_valid | input | 1 | Read command strobe |
| cmd_page | input | PA_W | Page address of the command |
| cmd_col | input | COL_W | Start column (normal mode only) |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_cont | input | 1 | Streaming-enable value to write |
| rd_req | input | 1 | Host requests one byte |
| rd_data | output | 8 | Output byte |
| rd_valid | output | 1 | `rd_data` holds a byte this cycle |
| busy | output | 1 | Load or recovery in progress |

## Verification
The main function is driven from three start points. A stream started at the first page of an erase block must yield four pages and then stop. A stream started at the third page must yield two pages, which separates the block-end rule from a fixed page count. A normal read at a non-zero column shows the spare bytes and the column being honoured, while the same column given in streaming mode is ignored. The host holds its request high continuously, so it outruns every array load. This proves that the stalls preserve byte order across each swap of halves. Each way of ending a stream is tested: chip-select release with a counted recovery wait, clearing the streaming bit with none, and a command issued during a load, which must be dropped.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

   typedef enum logic [2:0] {
      S_IDLE   = 3'd0,
      S_NLOAD  = 3'd1,
      S_NOUT   = 3'd2,
      S_FLOAD  = 3'd3,
      S_STREAM = 3'd4,
      S_RECOV  = 3'd5
   } ppc_state_e;

   // Content of the array model: a pure function of page and column.
   function automatic logic [7:0] arr_byte(input int unsigned page, input int unsigned col);
      int unsigned v;
      v = page * 29 + col * 7 + 60;
      return v[7:0];
   endfunction

endpackage

// File: rtl/ppc_loader.sv
// Array model plus load sequencer: waits LOAD_LAT cycles, then writes one
// byte per cycle into the chosen cache half.
module ppc_loader #(
   parameter int PAGE_TOTAL = 20,
   parameter int NUM_PAGES  = 16,
   parameter int LOAD_LAT   = 12,
   localparam int PA_W  = $clog2(NUM_PAGES),
   localparam int COL_W = $clog2(PAGE_TOTAL),
   localparam int LAT_W = $clog2(LOAD_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PA_W-1:0]  start_page,
   input  logic             start_half,
   input  logic             abort,
   output logic             busy,
   output logic             wr_en,
   output logic             wr_half,
   output logic [COL_W-1:0] wr_col,
   output logic [7:0]       wr_data,
   output logic             done
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_TOTAL - 1);

   logic             busy_q, xfer_q;
   logic [LAT_W-1:0] lat_q;
   logic [COL_W-1:0] col_q;
   logic [PA_W-1:0]  page_q;
   logic             half_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         xfer_q <= 1'b0;
         lat_q  <= '0;
         col_q  <= '0;
         page_q <= '0;
         half_q <= 1'b0;
      end else if (abort) begin
         busy_q <= 1'b0;
         xfer_q <= 1'b0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         xfer_q <= 1'b0;
         lat_q  <= LAT_W'(LOAD_LAT - 1);
         col_q  <= '0;
         page_q <= start_page;
         half_q <= start_half;
      end else if (busy_q && !xfer_q) begin
         if (lat_q == '0) xfer_q <= 1'b1;
         else             lat_q  <= lat_q - 1'b1;
      end else if (xfer_q) begin
         if (col_q == LAST_COL) begin
            busy_q <= 1'b0;
            xfer_q <= 1'b0;
         end else begin
            col_q <= col_q + 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign wr_en   = xfer_q;
   assign wr_half = half_q;
   assign wr_col  = col_q;
   assign wr_data = ppc_pkg::arr_byte(32'(page_q), 32'(col_q));
   assign done    = xfer_q && (col_q == LAST_COL);

endmodule

// File: rtl/ppc_cache.sv
// Two page-sized halves, one write port, one registered read port.
module ppc_cache #(
   parameter int PAGE_TOTAL = 20,
   localparam int COL_W = $clog2(PAGE_TOTAL)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic             wr_half,
   input  logic [COL_W-1:0] wr_col,
   input  logic [7:0]       wr_data,
   input  logic             rd_en,
   input  logic             rd_half,
   input  logic [COL_W-1:0] rd_col,
   output logic [7:0]       rd_data
);
   logic sel_q;

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [7:0] mem [PAGE_TOTAL];
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_half == 1'(h))) mem[wr_col] <= wr_data;
         if (rd_en && (rd_half == 1'(h))) q <= mem[rd_col];
      end
   end

   always_ff @(posedge clk) begin
      if (rd_en) sel_q <= rd_half;
   end

   assign rd_data = sel_q ? g_half[1].q : g_half[0].q;

endmodule

// File: rtl/ppc_ctrl.sv
// Command, streaming and recovery control.
module ppc_ctrl
   import ppc_pkg::*;
#(
   parameter int PAGE_BYTES    = 16,
   parameter int PAGE_TOTAL    = 20,
   parameter int NUM_PAGES     = 16,
   parameter int PAGES_PER_BLK = 4,
   parameter int RECOV_CYC     = 16,
   localparam int PA_W   = $clog2(NUM_PAGES),
   localparam int COL_W  = $clog2(PAGE_TOTAL),
   localparam int BLK_W  = $clog2(PAGES_PER_BLK),
   localparam int LEFT_W = BLK_W + 1,
   localparam int RC_W   = (RECOV_CYC > 1) ? $clog2(RECOV_CYC) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             cmd_valid,
   input  logic [PA_W-1:0]  cmd_page,
   input  logic [COL_W-1:0] cmd_col,
   input  logic             cfg_we,
   input  logic             cfg_cont,
   input  logic             rd_req,
   input  logic             ld_busy,
   input  logic             ld_done,
   input  logic             ld_wr_half,
   output logic             ld_start,
   output logic [PA_W-1:0]  ld_page,
   output logic             ld_half,
   output logic             ld_abort,
   output logic             rd_en,
   output logic             rd_half,
   output logic [COL_W-1:0] rd_col,
   output logic             rd_valid,
   output logic             busy,
   output ppc_state_e       state,
   output logic [PA_W-1:0]  base_page
);
   localparam logic [COL_W-1:0]  MAIN_LAST   = COL_W'(PAGE_BYTES - 1);
   localparam logic [COL_W-1:0]  TOTAL_LAST  = COL_W'(PAGE_TOTAL - 1);
   localparam logic [LEFT_W-1:0] LAST_IN_BLK = LEFT_W'(PAGES_PER_BLK - 1);
   localparam logic              HAS_RECOV   = (RECOV_CYC > 0);
   localparam logic [RC_W-1:0]   RC_LOAD     = RC_W'((RECOV_CYC > 0) ? RECOV_CYC - 1 : 0);

   ppc_state_e        st_q;
   logic              cont_en_q;
   logic [1:0]        full_q, full_d;
   logic              act_q;
   logic [COL_W-1:0]  ptr_q;
   logic              ndone_q;
   logic [PA_W-1:0]   nxt_q, base_q;
   logic [LEFT_W-1:0] left_q;
   logic [RC_W-1:0]   rcnt_q;
   logic              rd_valid_q;

   logic in_cont, term_cs, term_cfg, accept, n_issue, c_issue, issue;
   logic page_end;

   assign in_cont  = (st_q == S_FLOAD) || (st_q == S_STREAM);
   assign term_cs  = in_cont && cs_n;
   assign term_cfg = in_cont && !cs_n && cfg_we && !cfg_cont;
   assign accept   = (st_q == S_IDLE) && !cs_n && cmd_valid;
   assign n_issue  = (st_q == S_NOUT) && !cs_n && rd_req && !ndone_q;
   assign c_issue  = (st_q == S_STREAM) && !cs_n && !term_cfg && rd_req && full_q[act_q];
   assign issue    = n_issue || c_issue;
   assign page_end = c_issue && (ptr_q == MAIN_LAST);

   // Fetch the next page into the idle half whenever it is empty.
   assign ld_start = accept ||
                     ((st_q == S_STREAM) && !cs_n && !term_cfg && !ld_busy &&
                      (left_q != '0) && !full_q[~act_q]);
   assign ld_page  = accept ? cmd_page : nxt_q;
   assign ld_half  = accept ? 1'b0 : ~act_q;
   assign ld_abort = term_cs || term_cfg ||
                     (cs_n && ((st_q == S_NLOAD) || (st_q == S_NOUT)));

   always_comb begin
      full_d = full_q;
      if (ld_done)  full_d[ld_wr_half] = 1'b1;
      if (page_end) full_d[act_q]      = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= S_IDLE;
         cont_en_q  <= 1'b0;
         full_q     <= '0;
         act_q      <= 1'b0;
         ptr_q      <= '0;
         ndone_q    <= 1'b0;
         nxt_q      <= '0;
         base_q     <= '0;
         left_q     <= '0;
         rcnt_q     <= '0;
         rd_valid_q <= 1'b0;
      end else begin
         if (cfg_we) cont_en_q <= cfg_cont;
         rd_valid_q <= issue;
         unique case (st_q)
            S_IDLE: if (accept) begin
               base_q  <= cmd_page;
               nxt_q   <= cmd_page + 1'b1;
               left_q  <= cont_en_q ? (LAST_IN_BLK - LEFT_W'(cmd_page[BLK_W-1:0])) : '0;
               full_q  <= '0;
               act_q   <= 1'b0;
               ptr_q   <= cont_en_q ? '0 : cmd_col;
               ndone_q <= 1'b0;
               st_q    <= cont_en_q ? S_FLOAD : S_NLOAD;
            end
            S_NLOAD: begin
               if (cs_n)         st_q <= S_IDLE;
               else if (ld_done) st_q <= S_NOUT;
            end
            S_NOUT: begin
               if (cs_n) st_q <= S_IDLE;
               else if (n_issue) begin
                  if (ptr_q == TOTAL_LAST) ndone_q <= 1'b1;
                  else                     ptr_q   <= ptr_q + 1'b1;
               end
            end
            S_FLOAD, S_STREAM: begin
               if (term_cs) begin
                  full_q <= '0;
                  rcnt_q <= RC_LOAD;
                  st_q   <= HAS_RECOV ? S_RECOV : S_IDLE;
               end else if (term_cfg) begin
                  full_q <= '0;
                  st_q   <= S_IDLE;
               end else begin
                  full_q <= full_d;
                  if ((st_q == S_FLOAD) && ld_done) st_q <= S_STREAM;
                  if ((st_q == S_STREAM) && ld_start) begin
                     nxt_q  <= nxt_q + 1'b1;
                     left_q <= left_q - 1'b1;
                  end
                  if (c_issue) begin
                     if (page_end) begin
                        ptr_q <= '0;
                        act_q <= ~act_q;
                     end else begin
                        ptr_q <= ptr_q + 1'b1;
                     end
                  end
               end
            end
            S_RECOV: begin
               if (rcnt_q == '0) st_q   <= S_IDLE;
               else              rcnt_q <= rcnt_q - 1'b1;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign rd_en     = issue;
   assign rd_half   = (st_q == S_STREAM) ? act_q : 1'b0;
   assign rd_col    = ptr_q;
   assign rd_valid  = rd_valid_q;
   assign busy      = (st_q == S_NLOAD) || (st_q == S_FLOAD) || (st_q == S_RECOV);
   assign state     = st_q;
   assign base_page = base_q;

endmodule

// File: rtl/ppc_cont_read.sv
module ppc_cont_read
   import ppc_pkg::*;
#(
   parameter int PAGE_BYTES    = 16,
   parameter int SPARE_BYTES   = 4,
   parameter int NUM_PAGES     = 16,
   parameter int PAGES_PER_BLK = 4,
   parameter int LOAD_LAT      = 12,
   parameter int RECOV_CYC     = 16,
   localparam int PAGE_TOTAL = PAGE_BYTES + SPARE_BYTES,
   localparam int PA_W       = $clog2(NUM_PAGES),
   localparam int COL_W      = $clog2(PAGE_TOTAL),
   localparam int BLK_W      = $clog2(PAGES_PER_BLK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             cmd_valid,
   input  logic [PA_W-1:0]  cmd_page,
   input  logic [COL_W-1:0] cmd_col,
   input  logic             cfg_we,
   input  logic             cfg_cont,
   input  logic             rd_req,
   output logic [7:0]       rd_data,
   output logic             rd_valid,
   output logic             busy
);
   // Elaboration-time parameter checks
   if (PAGE_BYTES % 4 != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a multiple of 4");
   end
   if (PAGES_PER_BLK < 2 || (1 << BLK_W) != PAGES_PER_BLK) begin : g_bad_blk
      $error("PAGES_PER_BLK must be a power of two, at least 2");
   end
   if ((1 << PA_W) != NUM_PAGES || NUM_PAGES % PAGES_PER_BLK != 0) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two holding whole erase blocks");
   end
   if (LOAD_LAT < 1) begin : g_bad_lat
      $error("LOAD_LAT must be at least 1");
   end

   logic             ld_start, ld_half, ld_abort, ld_busy, ld_done;
   logic [PA_W-1:0]  ld_page, base_page;
   logic             ld_wr_en, ld_wr_half;
   logic [COL_W-1:0] ld_wr_col;
   logic [7:0]       ld_wr_data;
   logic             rd_en, rd_half;
   logic [COL_W-1:0] rd_col;
   ppc_state_e       st;

   ppc_ctrl #(
      .PAGE_BYTES(PAGE_BYTES), .PAGE_TOTAL(PAGE_TOTAL), .NUM_PAGES(NUM_PAGES),
      .PAGES_PER_BLK(PAGES_PER_BLK), .RECOV_CYC(RECOV_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
      .cmd_page(cmd_page), .cmd_col(cmd_col), .cfg_we(cfg_we), .cfg_cont(cfg_cont),
      .rd_req(rd_req), .ld_busy(ld_busy), .ld_done(ld_done), .ld_wr_half(ld_wr_half),
      .ld_start(ld_start), .ld_page(ld_page), .ld_half(ld_half), .ld_abort(ld_abort),
      .rd_en(rd_en), .rd_half(rd_half), .rd_col(rd_col), .rd_valid(rd_valid),
      .busy(busy), .state(st), .base_page(base_page)
   );

   ppc_loader #(
      .PAGE_TOTAL(PAGE_TOTAL), .NUM_PAGES(NUM_PAGES), .LOAD_LAT(LOAD_LAT)
   ) u_loader (
      .clk(clk), .rst_n(rst_n), .start(ld_start), .start_page(ld_page),
      .start_half(ld_half), .abort(ld_abort), .busy(ld_busy), .wr_en(ld_wr_en),
      .wr_half(ld_wr_half), .wr_col(ld_wr_col), .wr_data(ld_wr_data), .done(ld_done)
   );

   ppc_cache #(.PAGE_TOTAL(PAGE_TOTAL)) u_cache (
      .clk(clk), .wr_en(ld_wr_en), .wr_half(ld_wr_half), .wr_col(ld_wr_col),
      .wr_data(ld_wr_data), .rd_en(rd_en), .rd_half(rd_half), .rd_col(rd_col),
      .rd_data(rd_data)
   );

endmodule

// File: rtl/ppc_cont_read_chk.sv
module ppc_cont_read_chk
   import ppc_pkg::*;
#(
   parameter int PA_W  = 4,
   parameter int BLK_W = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cs_n,
   input logic            cfg_we,
   input logic            cfg_cont,
   input logic            rd_req,
   input logic            rd_valid,
   input logic            busy,
   input ppc_state_e      st,
   input logic            ld_start,
   input logic [PA_W-1:0] ld_page,
   input logic [PA_W-1:0] base_page,
   input logic            ld_wr_en,
   input logic            ld_wr_half,
   input logic            rd_en,
   input logic            rd_half
);
   a_r2_busy_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !rd_valid);

   a_r11_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(rd_req) && !$past(cs_n)));

   a_r7_release_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (((st == S_STREAM) || (st == S_FLOAD)) && cs_n) |=> busy);

   a_r8_clear_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (((st == S_STREAM) || (st == S_FLOAD)) && !cs_n && cfg_we && !cfg_cont)
      |=> (!busy && !rd_valid));

   a_r4_half_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_wr_en && rd_en && (st == S_STREAM)) |-> (ld_wr_half != rd_half));

   a_r6_same_block: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_start && (st == S_STREAM)) |->
      (ld_page[PA_W-1:BLK_W] == base_page[PA_W-1:BLK_W]));

endmodule

bind ppc_cont_read ppc_cont_read_chk #(.PA_W(PA_W), .BLK_W(BLK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_we(cfg_we), .cfg_cont(cfg_cont),
   .rd_req(rd_req), .rd_valid(rd_valid), .busy(busy), .st(st),
   .ld_start(ld_start), .ld_page(ld_page), .base_page(base_page),
   .ld_wr_en(ld_wr_en), .ld_wr_half(ld_wr_half), .rd_en(rd_en), .rd_half(rd_half)
);

// File: tb/tb_ppc_cont_read.sv
`timescale 1ns/1ps
module tb_ppc_cont_read;
   localparam int PB = 16, SP = 4, RC = 16;

   logic       clk = 0, rst_n = 0;
   logic       cs_n = 1, cmd_valid = 0, cfg_we = 0, cfg_cont = 0, rd_req = 0;
   logic [3:0] cmd_page = 0;
   logic [4:0] cmd_col = 0;
   logic [7:0] rd_data;
   logic       rd_valid, busy;

   int checks = 0, errors = 0;
   logic [7:0] got [128];
   int ngot, stalls;

   always #5 clk = ~clk;

   ppc_cont_read dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cmd_valid(cmd_valid),
      .cmd_page(cmd_page), .cmd_col(cmd_col), .cfg_we(cfg_we), .cfg_cont(cfg_cont),
      .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy)
   );

   function automatic logic [7:0] expb(int p, int c);
      int v;
      v = (29 * p + 7 * c + 60) % 256;
      return v[7:0];
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_cfg(bit v); // R12
      @(negedge clk); cfg_we = 1; cfg_cont = v;
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic issue_cmd(int p, int c);
      @(negedge clk); cs_n = 0; cmd_valid = 1; cmd_page = 4'(p); cmd_col = 5'(c);
      @(negedge clk); cmd_valid = 0;
   endtask

   task automatic wait_ready();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
   endtask

   task automatic collect(int max_cyc, int stop_after);
      bit started = 0;
      ngot = 0; stalls = 0; rd_req = 1;
      for (int i = 0; i < max_cyc; i++) begin
         @(negedge clk);
         if (rd_valid) begin
            if (ngot < 128) got[ngot] = rd_data;
            ngot++; started = 1;
         end else if (started) stalls++;
         if (ngot >= stop_after) begin
            rd_req = 0;
            @(negedge clk);
            if (rd_valid) begin
               if (ngot < 128) got[ngot] = rd_data;
               ngot++;
            end
            break;
         end
      end
      rd_req = 0;
   endtask

   task automatic check_stream(string req, int p0, int n);
      int bad = 0, first = -1;
      for (int i = 0; i < n && i < 128; i++)
         if (got[i] != expb(p0 + i / PB, i % PB)) begin
            bad++; if (first < 0) first = i;
         end
      chk(bad == 0, req, "stream bytes wrong at index", first, -1);
   endtask

   task automatic count_recovery(string req);
      int n = 0;
      @(negedge clk); cs_n = 1;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (busy) n++; else break;
      end
      chk(n == RC, req, "recovery busy cycles", n, RC);
   endtask

   task automatic t_reset();
      chk(busy == 0, "R1", "busy after reset", busy, 0);
      chk(rd_valid == 0, "R1", "rd_valid after reset", rd_valid, 0);
   endtask

   task automatic t_normal();
      int bad = 0;
      set_cfg(0);
      issue_cmd(5, 3);
      chk(busy == 1, "R2", "busy during normal load", busy, 1);
      wait_ready();
      collect(200, 1000);
      chk(ngot == PB + SP - 3, "R2", "normal byte count", ngot, PB + SP - 3);
      for (int i = 0; i < ngot && i < 128; i++) if (got[i] != expb(5, 3 + i)) bad++;
      chk(bad == 0, "R2", "normal bytes mismatching", bad, 0);
      @(negedge clk); cs_n = 1;
      @(negedge clk);
      chk(busy == 0, "R2", "busy after normal release", busy, 1'b0);
   endtask

   task automatic t_normal_release();
      int nv = 0;
      issue_cmd(2, 0);
      wait_ready();
      collect(200, 5);
      @(negedge clk); cs_n = 1; rd_req = 1;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (rd_valid) nv++;
         if (busy) nv += 100;
      end
      rd_req = 0;
      chk(nv == 0, "R9", "bytes or busy after release in normal read", nv, 0);
      chk(nv == 0, "R11", "rd_valid with cs_n high", nv, 0);
   endtask

   task automatic t_cont_block_start();
      set_cfg(1);
      issue_cmd(4, 7);
      chk(busy == 1, "R12", "busy during first streaming load", busy, 1);
      wait_ready();
      collect(1500, 1000);
      chk(ngot == 4 * PB, "R6", "bytes in a stream from block start", ngot, 4 * PB);
      chk(got[0] == expb(4, 0), "R3", "first streaming byte ignores column", got[0], expb(4, 0));
      check_stream("R4", 4, ngot);
      chk(stalls > 0, "R5", "stall cycles observed under fast host", stalls, 1);
      count_recovery("R7");
   endtask

   task automatic t_cont_mid_block();
      int nv = 0;
      issue_cmd(6, 0);
      wait_ready();
      collect(1000, 1000);
      chk(ngot == 2 * PB, "R6", "bytes in a stream from third page", ngot, 2 * PB);
      check_stream("R3", 6, ngot);
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (rd_valid) nv++; end
      chk(nv == 0, "R5", "bytes without request", nv, 0);
      count_recovery("R7");
   endtask

   task automatic t_cfg_clear();
      int nv = 0, nb = 0;
      issue_cmd(0, 0);
      wait_ready();
      collect(600, 20);
      check_stream("R4", 0, ngot);
      @(negedge clk); cfg_we = 1; cfg_cont = 0;
      @(negedge clk); cfg_we = 0;
      chk(busy == 0, "R8", "busy after streaming bit cleared", busy, 0);
      rd_req = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (rd_valid) nv++;
         if (busy) nb++;
      end
      rd_req = 0;
      chk(nv == 0, "R8", "bytes after streaming bit cleared", nv, 0);
      chk(nb == 0, "R8", "busy cycles after streaming bit cleared", nb, 0);
      @(negedge clk); cs_n = 1;
      @(negedge clk);
      chk(busy == 0, "R8", "no recovery after clear then release", busy, 0);
      set_cfg(1);
   endtask

   task automatic t_release_then_new();
      issue_cmd(8, 0);
      wait_ready();
      collect(600, 10);
      check_stream("R4", 8, ngot);
      count_recovery("R7");
      issue_cmd(9, 0);
      chk(busy == 1, "R7", "command accepted after recovery", busy, 1);
      wait_ready();
      collect(600, 4);
      check_stream("R7", 9, ngot);
      count_recovery("R7");
   endtask

   task automatic t_busy_ignore();
      issue_cmd(12, 5);
      @(negedge clk); cmd_valid = 1; cmd_page = 4'd1; cmd_col = 5'd0;
      @(negedge clk); cmd_valid = 0;
      wait_ready();
      collect(600, 16);
      check_stream("R10", 12, 16);
      count_recovery("R7");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_normal();
      t_normal_release();
      t_cont_block_start();
      t_cont_mid_block();
      t_cfg_clear();
      t_release_then_new();
      t_busy_ignore();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule